// File: doc/BRIEF.md
# Response-Handshake to Two-Phase Peripheral Write Bridge

This block lets a simple peripheral, one that expects a plain two-cycle write (a setup cycle, then an enable cycle), sit as a slave on a system bus. On that bus a slave must answer each transfer with a response code, and the write data only shows up after the slave has accepted. The bridge watches the system-side select and write lines. When both are high while it is idle, it latches the address and answers with an accept code. It captures the data word the bus presents in the following cycle, and then plays that address/data pair to the peripheral as one setup cycle followed by one enable cycle.

While the peripheral access is in progress, the bridge answers any further system-side select with the stall code. It only takes a new transfer once it is back in idle, so no word can be lost or sent twice. Reads, bursts, peripheral error reporting and transfer withdrawal are outside this block. The clock is a single rising edge for both sides. The reset is synchronous and active high.

Top module: `wr_bridge`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `per_sel`, `per_en` and `per_wr` are low and `sys_rsp` is the stall code.
- R2: `sys_rsp` carries a 3-bit response where stall=0, accept=1, last=2, error=3, withdraw=4; the bridge only ever drives 0 or 1.
- R3: When `sys_sel` and `sys_wr` are both high in a cycle in which the bridge is idle, `sys_rsp` is 1 for exactly the next cycle and 0 otherwise.
- R4: The address is the `sys_addr` value of the accepting cycle. The data is the `sys_wdata` value of the cycle that follows the accept-code cycle.
- R5: The cycle after data capture is a setup cycle: `per_sel`=1, `per_wr`=1, `per_en`=0, and `per_addr`/`per_wdata` equal the captured pair.
- R6: The setup cycle is followed by exactly one cycle with `per_en`=1. In the next cycle `per_sel` and `per_en` are both low.
- R7: `per_addr` and `per_wdata` do not change between the setup cycle and the enable cycle.
- R8: A select that arrives while a transfer is in progress (accept, data, setup or enable cycle) gets the stall code. It is only taken once the bridge is idle again, so back-to-back selects are served every 5 cycles.
- R9: A select with `sys_wr` low is not answered with the accept code and starts no peripheral access.
- R10: Each accepted transfer produces exactly one enable cycle on the peripheral side, in order of acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| sys_sel | input | 1 | System-side slave select |
| sys_wr | input | 1 | System-side write control |
| sys_addr | input | AW | System-side address |
| sys_wdata | input | DW | System-side write data, valid the cycle after the accept code |
| sys_rsp | output | 3 | Slave response code (0 stall, 1 accept) |
| per_sel | output | 1 | Peripheral select |
| per_en | output | 1 | Peripheral enable strobe |
| per_wr | output | 1 | Peripheral write control |
| per_addr | output | AW | Peripheral address |
| per_wdata | output | DW | Peripheral write data |

## Verification
Call the accepting cycle n. The accept code is due in cycle n+1 and the data is sampled from the bus in cycle n+2. The setup cycle is n+3, the enable cycle is n+4, and a new transfer can be taken at n+5. The bench advances a cycle-by-cycle model of these five phases with the same input values it drives. It compares every output at the falling edge, half a cycle after the register update. The bus address and data change every cycle, so a capture one cycle early or late produces a wrong value on the peripheral side.

// File: rtl/wbr_pkg.sv
package wbr_pkg;
  typedef enum logic [2:0] {
    RSP_STALL    = 3'd0,
    RSP_ACCEPT   = 3'd1,
    RSP_LAST     = 3'd2,
    RSP_ERROR    = 3'd3,
    RSP_WITHDRAW = 3'd4
  } rsp_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ACK,
    PH_DATA,
    PH_SETUP,
    PH_ACCESS
  } phase_e;
endpackage

// File: rtl/wbr_ctl.sv
module wbr_ctl
  import wbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_sel,
  input  logic       req_wr,
  output logic [2:0] rsp,
  output logic       ld_addr,
  output logic       ld_data,
  output logic       p_sel,
  output logic       p_en
);
  phase_e ph_q;
  rsp_e   rsp_q;

  assign ld_addr = (ph_q == PH_IDLE) && req_sel && req_wr;
  assign ld_data = (ph_q == PH_DATA);
  assign rsp     = rsp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      rsp_q <= RSP_STALL;
      p_sel <= 1'b0;
      p_en  <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (ld_addr) begin
            ph_q  <= PH_ACK;
            rsp_q <= RSP_ACCEPT;
          end
        end
        PH_ACK: begin
          ph_q  <= PH_DATA;
          rsp_q <= RSP_STALL;
        end
        PH_DATA: begin
          ph_q  <= PH_SETUP;
          p_sel <= 1'b1;
        end
        PH_SETUP: begin
          ph_q <= PH_ACCESS;
          p_en <= 1'b1;
        end
        PH_ACCESS: begin
          ph_q  <= PH_IDLE;
          p_sel <= 1'b0;
          p_en  <= 1'b0;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wbr_hold.sv
module wbr_hold #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/wr_bridge.sv
module wr_bridge #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sys_sel,
  input  logic          sys_wr,
  input  logic [AW-1:0] sys_addr,
  input  logic [DW-1:0] sys_wdata,
  output logic [2:0]    sys_rsp,
  output logic          per_sel,
  output logic          per_en,
  output logic          per_wr,
  output logic [AW-1:0] per_addr,
  output logic [DW-1:0] per_wdata
);
  logic ld_addr;
  logic ld_data;

  wbr_ctl ctl_i (
    .clk     (clk),
    .rst     (rst),
    .req_sel (sys_sel),
    .req_wr  (sys_wr),
    .rsp     (sys_rsp),
    .ld_addr (ld_addr),
    .ld_data (ld_data),
    .p_sel   (per_sel),
    .p_en    (per_en)
  );

  wbr_hold #(.W(AW)) addr_i (
    .clk (clk), .rst (rst), .ld (ld_addr), .d (sys_addr), .q (per_addr)
  );

  wbr_hold #(.W(DW)) data_i (
    .clk (clk), .rst (rst), .ld (ld_data), .d (sys_wdata), .q (per_wdata)
  );

  assign per_wr = per_sel;
endmodule

// File: rtl/wr_bridge_chk.sv
module wr_bridge_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] sys_addr,
  input logic [2:0]    sys_rsp,
  input logic          per_sel,
  input logic          per_en,
  input logic [AW-1:0] per_addr,
  input logic [DW-1:0] per_wdata
);
  AST_RSP_LEGAL: assert property (@(posedge clk) disable iff (rst)
    sys_rsp <= 3'd1); // R2
  AST_ACCEPT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    sys_rsp == 3'd1 |=> sys_rsp == 3'd0); // R3
  AST_ADDR_FROM_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    sys_rsp == 3'd1 |-> per_addr == $past(sys_addr)); // R4
  AST_SETUP_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
    sys_rsp == 3'd1 |=> ##1 (per_sel && !per_en)); // R5
  AST_SETUP_THEN_EN: assert property (@(posedge clk) disable iff (rst)
    (per_sel && !per_en) |=> (per_sel && per_en)); // R6
  AST_EN_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    per_en |=> (!per_sel && !per_en)); // R6
  AST_EN_HOLDS_PAIR: assert property (@(posedge clk) disable iff (rst)
    per_en |-> ($stable(per_addr) && $stable(per_wdata))); // R7
  AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (rst)
    per_sel |-> sys_rsp == 3'd0); // R8
endmodule

bind wr_bridge wr_bridge_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .sys_addr  (sys_addr),
  .sys_rsp   (sys_rsp),
  .per_sel   (per_sel),
  .per_en    (per_en),
  .per_addr  (per_addr),
  .per_wdata (per_wdata)
);

// File: tb/wr_bridge_tb_top.sv
module wr_bridge_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          sys_sel, sys_wr;
  logic [AW-1:0] sys_addr;
  logic [DW-1:0] sys_wdata;
  logic [2:0]    sys_rsp;
  logic          per_sel, per_en, per_wr;
  logic [AW-1:0] per_addr;
  logic [DW-1:0] per_wdata;

  int n_chk = 0;
  int n_bad = 0;
  int wd    = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  wr_bridge #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .sys_sel(sys_sel), .sys_wr(sys_wr),
    .sys_addr(sys_addr), .sys_wdata(sys_wdata), .sys_rsp(sys_rsp),
    .per_sel(per_sel), .per_en(per_en), .per_wr(per_wr),
    .per_addr(per_addr), .per_wdata(per_wdata)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // bench model: 0 idle, 1 accept, 2 data, 3 setup, 4 enable
  int            ph;
  logic [AW-1:0] ea;
  logic [DW-1:0] ed;
  int            n_acc;
  int            n_en;
  bit            last_sel;
  int            cyc;
  logic [15:0]   lfsr;

  task automatic cycle_step(input int p, input bit s, input bit w);
    string tr;
    @(negedge clk);
    tr = (ph >= 2 && last_sel) ? "R8" : "R3";
    check(tr, "sys_rsp", sys_rsp, (ph == 1) ? 1 : 0);
    check("R2", "rsp legal", (sys_rsp <= 3'd1), 1);
    check((p == 2) ? "R9" : "R5", "per_sel", per_sel, (ph == 3 || ph == 4));
    check("R5", "per_wr", per_wr, (ph == 3 || ph == 4));
    check("R6", "per_en", per_en, (ph == 4));
    if (ph == 3) begin
      check("R4", "setup addr", per_addr, ea);
      check("R4", "setup data", per_wdata, ed);
    end
    if (ph == 4) begin
      check("R7", "enable addr", per_addr, ea);
      check("R7", "enable data", per_wdata, ed);
      n_en++;
    end
    sys_sel   = s;
    sys_wr    = w;
    sys_addr  = AW'(cyc * 13 + 7);
    sys_wdata = DW'(cyc * 977 + 3);
    last_sel  = s;
    cyc++;
    case (ph)
      0: if (s && w) begin ph = 1; ea = sys_addr; end
      1: ph = 2;
      2: begin ph = 3; ed = sys_wdata; n_acc++; end
      3: ph = 4;
      default: ph = 0;
    endcase
  endtask

  initial begin
    rst = 1'b1; sys_sel = 0; sys_wr = 0; sys_addr = '0; sys_wdata = '0;
    ph = 0; ea = '0; ed = '0; n_acc = 0; n_en = 0; last_sel = 0; cyc = 0;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    check("R1", "reset per_sel", per_sel, 0);
    check("R1", "reset per_en", per_en, 0);
    check("R1", "reset per_wr", per_wr, 0);
    check("R1", "reset sys_rsp", sys_rsp, 0);
    rst = 1'b0;
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 80; i++) begin
        bit s, w;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (p)
          0: begin s = 1; w = 1; end
          1: begin s = i[0]; w = 1; end
          2: begin s = 1; w = (i % 7 == 0); end
          default: begin s = lfsr[0]; w = lfsr[3] | lfsr[5]; end
        endcase
        cycle_step(p, s, w);
      end
    end
    for (int i = 0; i < 8; i++) cycle_step(4, 0, 0);
    check("R10", "enable count vs accepted", n_en, n_acc);
    check("R8", "back-to-back accepts served", (n_acc > 30), 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule